// File: doc/BRIEF.md
# Gated External Interrupt Edge Detector

This block turns activity on five external interrupt pins and eight wake-up pins into sticky request flags. Every pin first passes through a two-flop synchronizer. Its synchronized level then goes through a function gate. While the pin's function enable is off, the gated line is held at 1. While the enable is on, the gated line follows the pin. An edge detector looks at the gated line, not at the raw pin. Because of this, turning a function on or off while the pin sits low is itself seen as an edge and can raise a flag.

Interrupt pins detect either falling or rising edges, chosen per pin by a polarity bit. Wake-up pins detect falling edges only. A small write port holds the three function-enable registers, the polarity register, the two flag-clear registers and the two flag-enable registers. The flags and the registered, enable-masked OR of all flags are the block's outputs.

Software must allow one idle cycle between a function-enable write and a flag clear. A clear written in the cycle directly after a function-enable write is dropped.

Top module: `ext_irq_edge_gate`

## Requirements
- R1: After reset, every flag, every enable, every polarity bit and `irq_out` are 0. Releasing reset while pins are low raises no flag.
- R2: For an interrupt pin whose function is on and whose polarity bit is 0, a high-to-low pin change sets its flag on the third rising clock edge after the change. A low-to-high change sets nothing.
- R3: For an interrupt pin whose function is on and whose polarity bit is 1, a low-to-high pin change sets its flag three edges later. A high-to-low change sets nothing.
- R4: With polarity 0, writing its function enable from 0 to 1 while the pin is low sets the flag on the edge after the write edge.
- R5: With polarity 1, writing its function enable from 1 to 0 while the pin is low sets the flag on the edge after the write edge.
- R6: A wake-up pin whose function is on sets its flag on a falling pin edge, and also when its enable goes 0 to 1 while the pin is low. A rising edge, or turning the enable off, sets nothing.
- R7: A pin whose function enable is 0 never sets its flag, whatever the pin does.
- R8: Writing 0 to a flag bit at the clear address clears that flag on the write edge. Writing 1 leaves it unchanged. When a set and an accepted clear hit the same flag in the same cycle, the flag ends at 1.
- R9: A clear write in the cycle directly after a write to any of the three function-enable registers has no effect. A clear written one idle cycle later is accepted.
- R10: The write map is as follows. Address 0 holds the enables of interrupts 1 to 4 in data bits 0 to 3. Address 1 holds the enable of interrupt 0 in bit 0. Address 2 holds the wake-up enables 0 to 7. Address 3 holds the interrupt polarity bits 0 to 4. Address 4 clears interrupt flags and address 5 clears wake-up flags. Address 6 holds the interrupt flag enables and address 7 the wake-up flag enables. Flag bit i always belongs to pin i.
- R11: `irq_out` equals the OR of every flag ANDed with its enable, one clock edge after the flags and enables it reflects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin | input | 5 | External interrupt pins, asynchronous |
| wkp_pin | input | 8 | Wake-up pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_flag | output | 5 | Sticky interrupt request flags |
| wkp_flag | output | 8 | Sticky wake-up request flags |
| irq_out | output | 1 | Registered OR of enabled flags |

## Verification
The same flag can be set and cleared in one cycle. To provoke this, the bench drops a wake-up pin and then times a clear write so that it lands on the third edge, the edge that records the detected fall. The flag is judged correct only if it reads 1 afterwards. A second collision is between a function-enable write and a clear write placed in the next cycle. For that case the bench rewrites an enable with its current value, so that no edge occurs. The flag must survive the clear. The bench then repeats the sequence with one idle cycle inserted, and this time the flag must be cleared.

// File: rtl/ext_irq_edge_gate.sv
module ext_irq_edge_gate #(
  parameter int N_IRQ = 5,
  parameter int N_WKP = 8,
  parameter int AW    = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic [N_WKP-1:0] wkp_pin,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [N_IRQ-1:0] irq_flag,
  output logic [N_WKP-1:0] wkp_flag,
  output logic             irq_out
);
  localparam int N_HI = N_IRQ - 1;
  localparam logic [AW-1:0] A_EN_HI  = AW'(0);
  localparam logic [AW-1:0] A_EN_0   = AW'(1);
  localparam logic [AW-1:0] A_EN_WK  = AW'(2);
  localparam logic [AW-1:0] A_POL    = AW'(3);
  localparam logic [AW-1:0] A_CLR_IR = AW'(4);
  localparam logic [AW-1:0] A_CLR_WK = AW'(5);
  localparam logic [AW-1:0] A_IE_IR  = AW'(6);
  localparam logic [AW-1:0] A_IE_WK  = AW'(7);

  logic [N_IRQ-1:0] irq_s1, irq_s2, irq_en, irq_pol, irq_prev, irq_ie;
  logic [N_WKP-1:0] wkp_s1, wkp_s2, wkp_en, wkp_prev, wkp_ie;
  logic [N_IRQ-1:0] irq_g, irq_hit, irq_clr;
  logic [N_WKP-1:0] wkp_g, wkp_hit, wkp_clr;
  logic             mode_wr, mode_wr_q, clr_ok;

  assign mode_wr = wr_en && (wr_addr == A_EN_HI || wr_addr == A_EN_0 || wr_addr == A_EN_WK);
  assign clr_ok  = wr_en && !mode_wr_q;

  assign irq_g = ~irq_en | irq_s2;
  assign wkp_g = ~wkp_en | wkp_s2;

  assign irq_hit = (irq_pol & ~irq_prev & irq_g) | (~irq_pol & irq_prev & ~irq_g);
  assign wkp_hit = wkp_prev & ~wkp_g;

  assign irq_clr = (clr_ok && wr_addr == A_CLR_IR) ? ~wr_data[N_IRQ-1:0] : '0;
  assign wkp_clr = (clr_ok && wr_addr == A_CLR_WK) ? ~wr_data[N_WKP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s1   <= '1;
      irq_s2   <= '1;
      wkp_s1   <= '1;
      wkp_s2   <= '1;
      irq_prev <= '1;
      wkp_prev <= '1;
    end else begin
      irq_s1   <= irq_pin;
      irq_s2   <= irq_s1;
      wkp_s1   <= wkp_pin;
      wkp_s2   <= wkp_s1;
      irq_prev <= irq_g;
      wkp_prev <= wkp_g;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en    <= '0;
      wkp_en    <= '0;
      irq_pol   <= '0;
      irq_ie    <= '0;
      wkp_ie    <= '0;
      mode_wr_q <= 1'b0;
    end else begin
      mode_wr_q <= mode_wr;
      if (wr_en) begin
        case (wr_addr)
          A_EN_HI: irq_en[N_IRQ-1:1] <= wr_data[N_HI-1:0];
          A_EN_0:  irq_en[0]         <= wr_data[0];
          A_EN_WK: wkp_en            <= wr_data[N_WKP-1:0];
          A_POL:   irq_pol           <= wr_data[N_IRQ-1:0];
          A_IE_IR: irq_ie            <= wr_data[N_IRQ-1:0];
          A_IE_WK: wkp_ie            <= wr_data[N_WKP-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= '0;
      wkp_flag <= '0;
      irq_out  <= 1'b0;
    end else begin
      irq_flag <= (irq_flag & ~irq_clr) | irq_hit;
      wkp_flag <= (wkp_flag & ~wkp_clr) | wkp_hit;
      irq_out  <= (|(irq_flag & irq_ie)) | (|(wkp_flag & wkp_ie));
    end
  end
endmodule

// File: rtl/ext_irq_edge_gate_chk.sv
module ext_irq_edge_gate_chk #(
  parameter int N_IRQ = 5,
  parameter int N_WKP = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [N_IRQ-1:0] irq_flag,
  input logic [N_WKP-1:0] wkp_flag,
  input logic             irq_out,
  input logic [N_IRQ-1:0] irq_hit,
  input logic [N_WKP-1:0] wkp_hit,
  input logic             mode_wr_q
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == AW'(4) || wr_addr == AW'(5));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (((irq_flag & $past(irq_flag)) == $past(irq_flag)) &&
                 ((wkp_flag & $past(wkp_flag)) == $past(wkp_flag))));

  a_r9_clear_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && mode_wr_q) |=> (((irq_flag & $past(irq_flag)) == $past(irq_flag)) &&
                               ((wkp_flag & $past(wkp_flag)) == $past(wkp_flag))));

  a_r2_irq_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flag & ~$past(irq_flag)) != '0) |-> ($past(irq_hit) != '0));

  a_r6_wkp_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((wkp_flag & ~$past(wkp_flag)) != '0) |-> ($past(wkp_hit) != '0));

  a_r11_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag == '0 && wkp_flag == '0) |=> !irq_out);
endmodule

bind ext_irq_edge_gate ext_irq_edge_gate_chk #(.N_IRQ(N_IRQ), .N_WKP(N_WKP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq_flag(irq_flag), .wkp_flag(wkp_flag), .irq_out(irq_out),
  .irq_hit(irq_hit), .wkp_hit(wkp_hit), .mode_wr_q(mode_wr_q)
);

// File: tb/test_ext_irq_edge_gate.sv
module test_ext_irq_edge_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] irq_pin;
  logic [7:0] wkp_pin;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] irq_flag;
  logic [7:0] wkp_flag;
  logic       irq_out;
  int total = 0;
  int bad = 0;

  // row: {enable, pin index[2:0], polarity, level before, level after, flag expected}
  localparam logic [7:0] VEC [8] = '{8'h85, 8'h82, 8'h9B, 8'h9C, 8'hC5, 8'hBB, 8'h24, 8'h3A};

  ext_irq_edge_gate i_ext_irq_edge_gate (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wkp_pin(wkp_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_flag(irq_flag), .wkp_flag(wkp_flag), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    irq_pin = '0; wkp_pin = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    chk("R1 irq flags", {3'b0, irq_flag}, 8'h00);
    chk("R1 wkp flags", wkp_flag, 8'h00);
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
    irq_pin = '1; wkp_pin = '1;
    idle(4);

    for (int r = 0; r < 8; r++) begin
      logic [7:0] v;
      int idx;
      string tag;
      v = VEC[r];
      idx = int'(v[6:4]);
      tag = !v[7] ? "R7 vector" : (v[3] ? "R3 vector" : "R2 vector");
      wr(3, 8'(v[3]) << idx);
      irq_pin = '1; irq_pin[idx] = v[2];
      wr(1, {7'b0, v[7] && idx == 0});
      wr(0, (v[7] && idx != 0) ? 8'(1 << (idx - 1)) : 8'h00);
      idle(4);
      wr(4, 8'h00);
      chk({tag, " pre"}, {3'b0, irq_flag}, 8'h00);
      irq_pin[idx] = v[1];
      idle(2);
      chk({tag, " early"}, {3'b0, irq_flag}, 8'h00);
      idle(1);
      chk(tag, {3'b0, irq_flag}, 8'(v[0]) << idx);
      wr(0, 8'h00); wr(1, 8'h00);
      irq_pin = '1;
      idle(4);
      wr(4, 8'h00); wr(5, 8'h00);
    end

    // R4 R10: enabling interrupt 2 (address 0 bit 1) while its pin is low
    wr(3, 8'h00);
    irq_pin[2] = 1'b0;
    idle(3);
    wr(0, 8'h02);
    chk("R4 not yet", {3'b0, irq_flag}, 8'h00);
    idle(1);
    chk("R4 R10 enable while low", {3'b0, irq_flag}, 8'h04);
    wr(3, 8'h04);
    idle(2);
    wr(4, 8'h00);
    chk("R8 clear", {3'b0, irq_flag}, 8'h00);
    wr(0, 8'h00);
    idle(1);
    chk("R5 disable while low", {3'b0, irq_flag}, 8'h04);
    irq_pin = '1;
    idle(3);
    wr(4, 8'h00);

    wkp_pin[5] = 1'b0;
    idle(3);
    wr(2, 8'h20);
    idle(1);
    chk("R6 enable while low", wkp_flag, 8'h20);
    idle(2);
    wr(5, 8'h00);
    wr(2, 8'h00);
    idle(1);
    chk("R6 disable sets nothing", wkp_flag, 8'h00);
    wkp_pin[5] = 1'b1;
    idle(3);
    wr(2, 8'h28);
    idle(2);
    wkp_pin[3] = 1'b0;
    idle(3);
    chk("R6 falling edge", wkp_flag, 8'h08);
    wr(5, 8'h00);
    wkp_pin[3] = 1'b1;
    idle(4);
    chk("R6 rising ignored", wkp_flag, 8'h00);

    wkp_pin[3] = 1'b0; wkp_pin[5] = 1'b0;
    idle(3);
    chk("R6 two falls", wkp_flag, 8'h28);
    wr(5, 8'hF7);
    chk("R8 selective clear", wkp_flag, 8'h20);

    wr(2, 8'h28);
    wr(5, 8'h00);
    chk("R9 clear dropped", wkp_flag, 8'h20);
    wr(2, 8'h28);
    idle(1);
    wr(5, 8'h00);
    chk("R9 clear accepted", wkp_flag, 8'h00);

    wkp_pin[3] = 1'b1;
    idle(3);
    wkp_pin[3] = 1'b0;
    idle(2);
    wr(5, 8'h00);
    chk("R8 set wins", wkp_flag, 8'h08);

    idle(2);
    chk("R11 masked", {7'b0, irq_out}, 8'h00);
    wr(7, 8'h08);
    chk("R11 lag", {7'b0, irq_out}, 8'h00);
    idle(1);
    chk("R11 raised", {7'b0, irq_out}, 8'h01);
    wr(5, 8'h00);
    chk("R11 hold", {7'b0, irq_out}, 8'h01);
    idle(1);
    chk("R11 dropped", {7'b0, irq_out}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule